// File: doc/BRIEF.md
# I2C Register-Access Slave Port

This block lets an external I2C master read and write a 16-bit-addressed register space inside the chip. It runs entirely on a fast system clock. It oversamples the open-drain SCL and SDA pins and removes short glitches from both. It then recognises start, repeated start and stop conditions, and turns the serial traffic into single-cycle strobes on a simple parallel register bus. The block only listens to SCL and never drives it. On SDA it can only pull the line low, through `sda_oe`.

The 7-bit device address has a fixed upper nibble. Its three low bits come from strap inputs that are captured during reset. A write transaction carries two register-address bytes, high byte first, followed by any number of data bytes. A read is a write of the register address, then a repeated start with the read bit set, then a burst of data bytes. The address pointer advances after every byte moved, in either direction. The register file itself sits outside the block. It answers a read strobe with data one clock later.

Top module: `i2c_regport`

## Requirements
- R1: The device address is binary 1001 in bits 6..3 and the strap value latched during reset in bits 2..0. The address byte is sent MSB first, and its bit 0 is the read/write flag (1 = read). A matching address byte is acknowledged by holding `sda_oe` = 1 through the ninth SCL pulse.
- R2: When the address byte does not match, the block gives no acknowledge and issues no register strobes. It ignores all bus traffic until the next start condition.
- R3: In a write, the two bytes after the address byte form the 16-bit register address, high byte first. Each later byte produces exactly one single-cycle `reg_wr_en` pulse carrying the current address and the byte. Every received byte is acknowledged.
- R4: The register pointer increments by one after each data byte written or read, and it wraps from 0xFFFF to 0x0000.
- R5: After a repeated start with the read bit set, the block returns the byte stored at the current pointer, MSB first. It sends a 0 bit by setting `sda_oe` = 1 and a 1 bit by releasing the line. The register file must present data on `reg_rdata` one cycle after `reg_rd_en`.
- R6: A read burst goes on as long as the master acknowledges. When the master answers with a no-acknowledge, the block releases SDA and stays released.
- R7: After reset, and after every stop condition, `sda_oe` is 0 and the block is idle. A start or repeated start restarts the bit and byte counting from the address byte.
- R8: A pulse on SCL or SDA that lasts fewer than `FILT_CYC` system-clock cycles has no effect on the bus decoding. The default of 11 cycles is 55 ns at 200 MHz.
- R9: `sda_oe` is asserted only while SCL is low. The block begins to pull SDA low only after a falling edge of SCL.
- R10: Transfers are decoded correctly at both 100 kHz and 400 kHz bus rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; the strap pins are captured while it is low |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| strap | input | 3 | Low three bits of the device address |
| sda_oe | output | 1 | 1 pulls the SDA pin low; 0 releases it |
| reg_wr_en | output | 1 | Single-cycle register write strobe |
| reg_rd_en | output | 1 | Single-cycle register read strobe |
| reg_addr | output | 16 | Register address that goes with either strobe |
| reg_wdata | output | 8 | Write data that goes with `reg_wr_en` |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd_en` |

## Verification
Every action of the block follows an SCL edge. Each edge passes through two synchroniser stages, `FILT_CYC` filter cycles, one edge register and one control register, so the block answers about 15 system cycles after the pin moves. The bench's master therefore samples the acknowledge and read bits one quarter bus period after SCL rises, long after the block's SDA change has settled, and it never reads in the edge window. Register strobes are compared on every clock, on the falling system edge, against a queue of expected writes. That check places no timing limit on the strobe beyond "before the next byte".

// File: rtl/i2c_regport_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the I2C register port.
// Assumes byte-wide data and a 16-bit register address space.
package i2c_regport_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_RAH,
        PH_RAL,
        PH_WDATA,
        PH_RDATA
    } phase_t;

    localparam int          REG_AW     = 16;
    localparam int          BYTE_W     = 8;
    localparam logic [3:0]  DEV_NIBBLE = 4'b1001;
endpackage

// File: rtl/i2c_pin_filter.sv
`timescale 1ns/1ps
// Synchronises one bus pin into the system clock and rejects pulses
// shorter than FILT_CYC cycles. The output follows the synchronised
// input only after it has held a new value for FILT_CYC consecutive cycles.
// Assumes the bus idles high, so the reset value is 1.
module i2c_pin_filter #(
    parameter int FILT_CYC    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;
    logic                   raw;

    // Metastability chain for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
    end

    assign raw = sync_q[SYNC_STAGES-1];

    // Count how long the input has differed from the output; flip once it has lasted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= 1'b1;
            run_cnt <= '0;
        end else if (raw == level) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_CYC - 1)) begin
            level   <= raw;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
`timescale 1ns/1ps
// Turns the filtered SCL/SDA levels into single-cycle events:
// SCL rising, SCL falling, start (SDA falls while SCL high) and
// stop (SDA rises while SCL high). Assumes clean, filtered inputs.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_prev;
    logic sda_prev;

    // Hold last cycle's levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    // Decode the edge and condition events.
    always_comb begin
        scl_rise = !scl_prev && scl_lvl;
        scl_fall = scl_prev && !scl_lvl;
        start_ev = scl_prev && scl_lvl && sda_prev && !sda_lvl;
        stop_ev  = scl_prev && scl_lvl && !sda_prev && sda_lvl;
    end
endmodule

// File: rtl/i2c_slave_ctrl.sv
`timescale 1ns/1ps
// Byte-level protocol engine: address match, two-byte register
// address, write data, read bursts and acknowledge handling.
// Assumes the register file returns read data one cycle after reg_rd_en.
// SDA changes are made only on SCL falling events.
module i2c_slave_ctrl
    import i2c_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              sda_lvl,
    input  logic [2:0]        dev_low,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [REG_AW-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output phase_t            phase
);
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic [REG_AW-1:0] ptr;
    logic              rnw;
    logic              mst_ack;
    logic              rd_pend;
    logic              addr_hit;

    assign addr_hit = (shreg[7:1] == {DEV_NIBBLE, dev_low});

    // Main protocol sequencer, advanced by bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            txreg     <= '0;
            ptr       <= '0;
            rnw       <= 1'b0;
            mst_ack   <= 1'b0;
            rd_pend   <= 1'b0;
            sda_oe    <= 1'b0;
            reg_wr_en <= 1'b0;
            reg_rd_en <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else begin
            reg_wr_en <= 1'b0;
            reg_rd_en <= 1'b0;
            rd_pend   <= reg_rd_en;
            if (start_ev) begin
                phase   <= PH_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_ev) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (phase != PH_RDATA && bit_cnt < 4'd8)
                        shreg <= {shreg[6:0], sda_lvl};
                    if (phase == PH_RDATA && bit_cnt == 4'd8) begin
                        mst_ack <= !sda_lvl;
                        if (!sda_lvl) begin
                            reg_rd_en <= 1'b1;
                            reg_addr  <= ptr;
                            ptr       <= ptr + 1'b1;
                        end
                    end
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall) begin
                    if (bit_cnt == 4'd8) begin
                        if (phase == PH_RDATA) begin
                            sda_oe <= 1'b0;
                        end else begin
                            case (phase)
                                PH_DEV: begin
                                    if (addr_hit) begin
                                        sda_oe <= 1'b1;
                                        rnw    <= shreg[0];
                                        if (shreg[0]) begin
                                            reg_rd_en <= 1'b1;
                                            reg_addr  <= ptr;
                                            ptr       <= ptr + 1'b1;
                                        end
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                                PH_RAH: begin
                                    ptr[15:8] <= shreg;
                                    sda_oe    <= 1'b1;
                                end
                                PH_RAL: begin
                                    ptr[7:0] <= shreg;
                                    sda_oe   <= 1'b1;
                                end
                                PH_WDATA: begin
                                    reg_wr_en <= 1'b1;
                                    reg_addr  <= ptr;
                                    reg_wdata <= shreg;
                                    ptr       <= ptr + 1'b1;
                                    sda_oe    <= 1'b1;
                                end
                                default: sda_oe <= 1'b0;
                            endcase
                        end
                    end else if (bit_cnt == 4'd9) begin
                        bit_cnt <= '0;
                        case (phase)
                            PH_DEV: begin
                                if (rnw) begin
                                    phase  <= PH_RDATA;
                                    sda_oe <= !txreg[7];
                                    txreg  <= {txreg[6:0], 1'b0};
                                end else begin
                                    phase  <= PH_RAH;
                                    sda_oe <= 1'b0;
                                end
                            end
                            PH_RAH: begin
                                phase  <= PH_RAL;
                                sda_oe <= 1'b0;
                            end
                            PH_RAL: begin
                                phase  <= PH_WDATA;
                                sda_oe <= 1'b0;
                            end
                            PH_RDATA: begin
                                if (mst_ack) begin
                                    sda_oe <= !txreg[7];
                                    txreg  <= {txreg[6:0], 1'b0};
                                end else begin
                                    phase  <= PH_IDLE;
                                    sda_oe <= 1'b0;
                                end
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (phase == PH_RDATA) begin
                        sda_oe <= !txreg[7];
                        txreg  <= {txreg[6:0], 1'b0};
                    end
                end
            end
            if (rd_pend) txreg <= reg_rdata;
        end
    end
endmodule

// File: rtl/i2c_regport.sv
`timescale 1ns/1ps
// Top level of the I2C register-access slave. It filters both bus pins,
// decodes bus events and drives the register bus through the protocol engine.
// Assumes an external open-drain pad: sda_oe = 1 pulls SDA low.
// SCL is input only; the block never stretches the clock.
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter int FILT_CYC    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        strap,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [REG_AW-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int NPINS = 2;

    logic [NPINS-1:0] pins_raw;
    logic [NPINS-1:0] pins_flt;
    logic             scl_f;
    logic             sda_f;
    logic             scl_rise, scl_fall, start_ev, stop_ev;
    logic [2:0]       strap_q;
    phase_t           ctrl_phase;

    assign pins_raw = {sda_in, scl_in};

    for (genvar g = 0; g < NPINS; g++) begin : g_filt
        i2c_pin_filter #(
            .FILT_CYC   (FILT_CYC),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_in(pins_raw[g]),
            .level (pins_flt[g])
        );
    end

    assign scl_f = pins_flt[0];
    assign sda_f = pins_flt[1];

    // Capture the address strap pins while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap;
    end

    i2c_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_lvl (scl_f),
        .sda_lvl (sda_f),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    i2c_slave_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_lvl  (sda_f),
        .dev_low  (strap_q),
        .reg_rdata(reg_rdata),
        .sda_oe   (sda_oe),
        .reg_wr_en(reg_wr_en),
        .reg_rd_en(reg_rd_en),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .phase    (ctrl_phase)
    );
endmodule

// File: rtl/i2c_regport_chk.sv
`timescale 1ns/1ps
// Protocol checker bound into the I2C register port.
// Observes the filtered SCL level, the control phase and the register bus.
module i2c_regport_chk
    import i2c_regport_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   scl_f,
    input logic   sda_oe,
    input logic   reg_wr_en,
    input logic   reg_rd_en,
    input phase_t phase
);
    // R9: pulling SDA low only starts while SCL is low.
    assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);

    // R7: an idle block never holds SDA.
    assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_oe);

    // R3: write strobes last exactly one cycle.
    assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R3: writes only come from the data phase of a write.
    assert_wr_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (phase == PH_WDATA));

    // R5: read strobes only come from a read address or read burst.
    assert_rd_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> (phase == PH_DEV || phase == PH_RDATA));

    // R3: both strobes are never raised together.
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));
endmodule

bind i2c_regport i2c_regport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_oe   (sda_oe),
    .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en),
    .phase    (ctrl_phase)
);

// File: tb/i2c_regport_test.sv
`timescale 1ns/1ps
// Bench: behavioural I2C master, register-file model and strobe monitor.
module i2c_regport_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        glitch_scl = 1'b0, glitch_sda = 1'b0, glitch_en = 1'b0;
    logic        scl_pin, sda_pin;
    logic [2:0]  strap = 3'b101;
    logic        sda_oe, reg_wr_en, reg_rd_en;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata = 8'h00;

    int checks = 0, bad = 0, q = 125;
    bit done = 0, oe_prev = 0;
    logic [7:0]  mem [int];
    logic [23:0] exp_wr [$];

    localparam logic [6:0] DEV = 7'b1001101;

    always #2.5 clk = ~clk;

    assign scl_pin = scl_m & ~glitch_scl;
    assign sda_pin = (sda_m ^ glitch_sda) & ~sda_oe;

    i2c_regport uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_pin), .sda_in(sda_pin),
        .strap(strap), .sda_oe(sda_oe), .reg_wr_en(reg_wr_en),
        .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] fetch(input int a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Register-file model.
    always @(posedge clk) begin
        if (reg_wr_en) mem[int'(reg_addr)] = reg_wdata;
    end
    always @(posedge clk) begin
        if (reg_rd_en) reg_rdata <= fetch(int'(reg_addr));
    end

    // Per-clock comparison of strobes and SDA drive against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr_en) begin
                if (exp_wr.size() == 0) chk(0, "R3 unexpected write", {reg_addr, reg_wdata}, 0);
                else begin
                    logic [23:0] e;
                    e = exp_wr.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R3/R4 write addr+data", {reg_addr, reg_wdata}, e);
                end
            end
            if (sda_oe && !oe_prev) chk(!scl_m, "R9 SDA pulled while SCL high", scl_m, 0);
        end
        oe_prev = sda_oe;
    end

    task automatic qwait();
        repeat (q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; qwait(); scl_m = 1; qwait(); sda_m = 0; qwait(); scl_m = 0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 0; qwait(); scl_m = 1; qwait(); sda_m = 1; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait(); scl_m = 1; qwait();
            if (glitch_en) begin
                glitch_scl = 1; repeat (8) @(negedge clk); glitch_scl = 0;
                repeat (10) @(negedge clk);
                glitch_sda = 1; repeat (8) @(negedge clk); glitch_sda = 0;
            end
            qwait(); scl_m = 0; qwait();
        end
        sda_m = 1; qwait(); scl_m = 1; qwait();
        ack = !sda_pin;
        qwait(); scl_m = 0; qwait();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        b = 0;
        sda_m = 1;
        for (int i = 0; i < 8; i++) begin
            qwait(); scl_m = 1; qwait();
            b = {b[6:0], sda_pin};
            qwait(); scl_m = 0; qwait();
        end
        sda_m = !give_ack; qwait(); scl_m = 1; qwait(); qwait(); scl_m = 0; qwait();
        sda_m = 1;
    endtask

    task automatic set_pointer(input logic [15:0] a);
        bit ack;
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R1 address ack", ack, 1);
        send_byte(a[15:8], ack);     chk(ack, "R3 addr high ack", ack, 1);
        send_byte(a[7:0], ack);      chk(ack, "R3 addr low ack", ack, 1);
    endtask

    task automatic write_regs(input logic [15:0] a, input logic [7:0] d [$]);
        bit ack;
        set_pointer(a);
        foreach (d[i]) begin
            if (i == d.size() - 1 && glitch_en) ;
            exp_wr.push_back({a + 16'(i), d[i]});
            send_byte(d[i], ack); chk(ack, "R3 data ack", ack, 1);
        end
        bus_stop();
        chk(exp_wr.size() == 0, "R3 all writes seen", exp_wr.size(), 0);
        chk(!sda_oe, "R7 released after stop", sda_oe, 0);
    endtask

    task automatic read_regs(input logic [15:0] a, input int n);
        bit ack;
        logic [7:0] b;
        set_pointer(a);
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk(ack, "R5 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [15:0] ea;
            ea = a + 16'(i);
            recv_byte(b, i < n - 1);
            chk(b == fetch(int'(ea)), "R5/R4/R6 read data", b, fetch(int'(ea)));
        end
        chk(!sda_oe, "R6 released after nack", sda_oe, 0);
        qwait();
        chk(!sda_oe, "R6 stays released", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        bit ack;
        int rd_before;
        repeat (10) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        chk(!sda_oe, "R7 reset sda_oe", sda_oe, 0);
        chk(!reg_wr_en && !reg_rd_en, "R7 reset strobes", {reg_wr_en, reg_rd_en}, 0);

        // Fast mode write across a byte boundary of the address (R1, R3, R4, R10).
        q = 125;
        write_regs(16'h12FF, '{8'hA1, 8'hB2});

        // Wrong device address: silent, no strobes (R2).
        bus_start();
        send_byte({7'b1001100, 1'b0}, ack);
        chk(!ack, "R2 mismatch not acked", ack, 0);
        chk(!sda_oe, "R2 line released", sda_oe, 0);
        bus_stop();
        chk(exp_wr.size() == 0, "R2 no write", exp_wr.size(), 0);

        // Read back the two bytes with a burst (R5, R6).
        read_regs(16'h12FF, 2);

        // Pointer wrap on read (R4).
        read_regs(16'hFFFF, 2);

        // Glitches on both lines during the data byte (R8).
        glitch_en = 1;
        write_regs(16'h0040, '{8'h3C});
        glitch_en = 0;
        chk(fetch(32'h40) == 8'h3C, "R8 glitched byte stored", fetch(32'h40), 8'h3C);

        // Standard mode write (R10).
        q = 500;
        write_regs(16'h0007, '{8'h99});
        chk(fetch(32'h7) == 8'h99, "R10 standard mode byte stored", fetch(32'h7), 8'h99);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule